// File: doc/BRIEF.md
# SDRAM Byte-Lane Data Mask Control

This block sits on the device side of a synchronous DRAM data path. It takes the data mask pins and uses them for two different jobs. During write beats a high mask stops its byte lane from being written, and it does so in the same clock cycle. During read beats a high mask turns off that lane's output drivers, but only two clocks after the mask is sampled. Each output driver is modelled as a data vector plus one enable per byte lane, not as a true bidirectional bus.

The data width is a parameter and may be 4, 8 or 16 bits. At 16 bits there are two mask inputs. Mask bit 0 covers data bits 7..0 and mask bit 1 covers data bits 15..8. At 4 or 8 bits a single mask bit covers every data bit. The surrounding logic marks each cycle as a write beat or a read beat. It supplies the read data from the array already lined up with the output stage. It uses the per-lane and per-bit write strobes to gate array writes.

Top module: `sdram_lane_mask_ctrl`

## Requirements
- R1: A rising clock edge with `rst_n` low clears the read pipeline. After that edge `rd_lane_oe` is all zero and `rd_data_out` is zero until a new read beat reaches the output stage.
- R2: `wr_lane_en[i]` is 1 in a cycle exactly when `wr_beat` is 1 and `dqm[i]` is 0 in that same cycle. A mask value of 1 blocks the write and 0 allows it.
- R3: `rd_lane_oe[i]` in cycle n+2 is 1 exactly when, in cycle n, `rd_beat` was 1 and `dqm[i]` was 0. A mask value of 1 gives high impedance.
- R4: Masking works one beat at a time. A masked beat inside a burst does not change the strobes or enables of the unmasked beats before or after it.
- R5: With `DATA_W`=16, mask bit 0 controls data bits 7..0 and mask bit 1 controls data bits 15..8, for both writes and reads.
- R6: With `DATA_W` of 4 or 8 there is one mask bit, and it controls every data bit.
- R7: `wr_bit_en` copies each lane's write strobe onto every bit of that lane. `rd_bit_oe` does the same with the lane output enable. `rd_data_out` equals `rd_data_in` on enabled lanes and is zero on disabled lanes.
- R8: A mask value given in a cycle with no beat has no effect. With `wr_beat` low no write strobe rises, and with `rd_beat` low no lane is enabled two cycles later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_beat | input | 1 | A write data beat is present this cycle |
| rd_beat | input | 1 | A read beat is sampled this cycle |
| dqm | input | MASK_W | Per-lane mask, 1 = masked or disabled |
| rd_data_in | input | DATA_W | Read data from the array, aligned to the output stage |
| wr_lane_en | output | MASK_W | Per-lane write strobe toward the array |
| wr_bit_en | output | DATA_W | Per-bit write enable toward the array |
| rd_lane_oe | output | MASK_W | Per-lane output-driver enable |
| rd_bit_oe | output | DATA_W | Per-bit output-driver enable |
| rd_data_out | output | DATA_W | Data presented to the drivers, zero on disabled lanes |

## Verification
The bench targets the different latencies of the two paths. If a design delayed the write mask, the write strobes in the table would land one row late. If a design used a read latency of one or three cycles, the enables would appear on the wrong rows. The bench varies the two mask bits separately so that a swap of the lane mapping shows up as a wrong half-word. It also gives masks in cycles with no beat, and starts a reset while a read is still in the pipeline, so a pipeline that missed the reset would enable drivers on the cycle after it. A second instance at 8 bits checks that a single mask bit covers the whole bus.

// File: rtl/sdram_lm_pkg.sv
// Package: shared constants and width helpers for the byte-lane mask control.
// Assumes data widths of 4, 8 or 16 bits only.
package sdram_lm_pkg;

    // Clocks between sampling a read mask and its effect on the drivers.
    localparam int RD_HIZ_LAT = 2;

    // Number of mask bits for a given data width.
    function automatic int mask_bits(input int data_w);
        return (data_w == 16) ? 2 : 1;
    endfunction

    // True when the width is one of the supported organizations.
    function automatic bit width_ok(input int data_w);
        return (data_w == 4) || (data_w == 8) || (data_w == 16);
    endfunction

endpackage

// File: rtl/lm_wr_gate.sv
// Write gate: turns the beat flag and the mask into per-lane write strobes
// in the same cycle (zero latency). Purely combinational.
// Assumes: dqm is stable around the edge at which the array captures data.
module lm_wr_gate #(
    parameter int MASK_W = 2
) (
    input  logic              wr_beat,
    input  logic [MASK_W-1:0] dqm,
    output logic [MASK_W-1:0] lane_en
);

    for (genvar i = 0; i < MASK_W; i++) begin : g_lane
        // Strobe a lane only on a write beat whose mask bit is clear.
        always_comb begin
            lane_en[i] = wr_beat & ~dqm[i];
        end
    end

endmodule

// File: rtl/lm_rd_pipe.sv
// Read disable pipeline: registers the per-lane read enable (beat and not
// masked) through DEPTH rising-edge stages. Synchronous active-low reset
// clears every stage, so the drivers are off after reset.
// Assumes DEPTH >= 2.
module lm_rd_pipe #(
    parameter int MASK_W = 2,
    parameter int DEPTH  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_beat,
    input  logic [MASK_W-1:0] dqm,
    output logic [MASK_W-1:0] lane_oe
);

    localparam int LAST = DEPTH - 1;

    for (genvar i = 0; i < MASK_W; i++) begin : g_lane
        logic [DEPTH-1:0] stage_q;

        // Shift this lane's enable toward the output stage.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                stage_q <= '0;
            end else begin
                stage_q <= {stage_q[DEPTH-2:0], rd_beat & ~dqm[i]};
            end
        end

        // The last stage drives the lane's output enable.
        always_comb begin
            lane_oe[i] = stage_q[LAST];
        end
    end

endmodule

// File: rtl/lm_lane_fan.sv
// Lane fan-out: copies each lane control bit onto all data bits of that lane.
// Assumes DATA_W is a whole multiple of MASK_W.
module lm_lane_fan #(
    parameter int DATA_W = 16,
    parameter int MASK_W = 2
) (
    input  logic [MASK_W-1:0] lane_bits,
    output logic [DATA_W-1:0] bit_vec
);

    localparam int LANE_W = DATA_W / MASK_W;

    for (genvar b = 0; b < DATA_W; b++) begin : g_bit
        // Each bit follows the lane that owns it.
        always_comb begin
            bit_vec[b] = lane_bits[b / LANE_W];
        end
    end

endmodule

// File: rtl/sdram_lane_mask_ctrl.sv
// Top: device-side byte-lane mask control. The write path gates array writes
// in the cycle the mask is sampled. The read path disables the output drivers
// RD_HIZ_LAT clocks after the mask is sampled.
// Assumes: read data arrives already aligned to the output stage, and the
// caller does not mark one cycle as both a write beat and a read beat.
module sdram_lane_mask_ctrl
    import sdram_lm_pkg::*;
#(
    parameter int DATA_W = 16,
    localparam int MASK_W = mask_bits(DATA_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_beat,
    input  logic              rd_beat,
    input  logic [MASK_W-1:0] dqm,
    input  logic [DATA_W-1:0] rd_data_in,
    output logic [MASK_W-1:0] wr_lane_en,
    output logic [DATA_W-1:0] wr_bit_en,
    output logic [MASK_W-1:0] rd_lane_oe,
    output logic [DATA_W-1:0] rd_bit_oe,
    output logic [DATA_W-1:0] rd_data_out
);

    if (!width_ok(DATA_W)) begin : g_bad_width
        $error("sdram_lane_mask_ctrl: DATA_W must be 4, 8 or 16");
    end

    lm_wr_gate #(.MASK_W(MASK_W)) u_wr_gate (
        .wr_beat (wr_beat),
        .dqm     (dqm),
        .lane_en (wr_lane_en)
    );

    lm_rd_pipe #(.MASK_W(MASK_W), .DEPTH(RD_HIZ_LAT)) u_rd_pipe (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_beat (rd_beat),
        .dqm     (dqm),
        .lane_oe (rd_lane_oe)
    );

    lm_lane_fan #(.DATA_W(DATA_W), .MASK_W(MASK_W)) u_wr_fan (
        .lane_bits (wr_lane_en),
        .bit_vec   (wr_bit_en)
    );

    lm_lane_fan #(.DATA_W(DATA_W), .MASK_W(MASK_W)) u_rd_fan (
        .lane_bits (rd_lane_oe),
        .bit_vec   (rd_bit_oe)
    );

    // Zero the data on disabled lanes so nothing leaks onto the drivers.
    always_comb begin
        rd_data_out = rd_data_in & rd_bit_oe;
    end

endmodule

// File: rtl/lm_checker.sv
// Checker: temporal properties of the byte-lane mask control, bound to the top.
module lm_checker #(
    parameter int DATA_W = 16,
    parameter int MASK_W = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_beat,
    input logic              rd_beat,
    input logic [MASK_W-1:0] dqm,
    input logic [DATA_W-1:0] rd_data_in,
    input logic [MASK_W-1:0] wr_lane_en,
    input logic [DATA_W-1:0] wr_bit_en,
    input logic [MASK_W-1:0] rd_lane_oe,
    input logic [DATA_W-1:0] rd_bit_oe,
    input logic [DATA_W-1:0] rd_data_out
);

    localparam int LANE_W = DATA_W / MASK_W;

    // R1: the edge after a reset cycle leaves every driver disabled.
    assert_reset_clears_R1: assert property (@(posedge clk)
        !rst_n |=> (rd_lane_oe == '0));

    for (genvar i = 0; i < MASK_W; i++) begin : g_lane
        // R2: a set mask bit blocks its write strobe in the same cycle.
        assert_wr_mask_blocks_R2: assert property (@(posedge clk) disable iff (!rst_n)
            dqm[i] |-> !wr_lane_en[i]);
        // R2: an unmasked write beat strobes its lane in the same cycle.
        assert_wr_open_lane_R2: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_beat && !dqm[i]) |-> wr_lane_en[i]);
        // R3: an unmasked read beat enables the lane two clocks later.
        assert_rd_enable_lat_R3: assert property (@(posedge clk) disable iff (!rst_n)
            (rd_beat && !dqm[i]) |-> ##2 rd_lane_oe[i]);
        // R3: a masked read beat leaves the lane disabled two clocks later.
        assert_rd_hiz_lat_R3: assert property (@(posedge clk) disable iff (!rst_n)
            (rd_beat && dqm[i]) |-> ##2 !rd_lane_oe[i]);
        // R8: a cycle with no read beat cannot enable a lane two clocks later.
        assert_no_beat_no_oe_R8: assert property (@(posedge clk) disable iff (!rst_n)
            !rd_beat |-> ##2 !rd_lane_oe[i]);
    end

    // R8: no write beat means no write strobes.
    assert_no_wr_beat_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_beat |-> (wr_lane_en == '0));

    for (genvar b = 0; b < DATA_W; b++) begin : g_bit
        // R7: per-bit enables follow their lane and data is zero when disabled.
        assert_bit_follow_R7: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_bit_en[b] == wr_lane_en[b / LANE_W]) &&
            (rd_bit_oe[b] == rd_lane_oe[b / LANE_W]) &&
            (rd_data_out[b] == (rd_data_in[b] & rd_lane_oe[b / LANE_W])));
    end

endmodule

bind sdram_lane_mask_ctrl lm_checker #(.DATA_W(DATA_W), .MASK_W(MASK_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_beat     (wr_beat),
    .rd_beat     (rd_beat),
    .dqm         (dqm),
    .rd_data_in  (rd_data_in),
    .wr_lane_en  (wr_lane_en),
    .wr_bit_en   (wr_bit_en),
    .rd_lane_oe  (rd_lane_oe),
    .rd_bit_oe   (rd_bit_oe),
    .rd_data_out (rd_data_out)
);

// File: tb/sim_sdram_lane_mask_ctrl.sv
module sim_sdram_lane_mask_ctrl;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2 clk = ~clk;   // 250 MHz

    int total = 0;
    int bad = 0;

    // 16-bit instance
    logic        wr_beat, rd_beat;
    logic [1:0]  dqm;
    logic [15:0] rd_data_in;
    logic [1:0]  wr_lane_en, rd_lane_oe;
    logic [15:0] wr_bit_en, rd_bit_oe, rd_data_out;

    sdram_lane_mask_ctrl #(.DATA_W(16)) u0 (
        .clk(clk), .rst_n(rst_n), .wr_beat(wr_beat), .rd_beat(rd_beat),
        .dqm(dqm), .rd_data_in(rd_data_in), .wr_lane_en(wr_lane_en),
        .wr_bit_en(wr_bit_en), .rd_lane_oe(rd_lane_oe), .rd_bit_oe(rd_bit_oe),
        .rd_data_out(rd_data_out)
    );

    // 8-bit instance
    logic       wr_beat8, rd_beat8;
    logic [0:0] dqm8;
    logic [7:0] rd_data_in8;
    logic [0:0] wr_lane_en8, rd_lane_oe8;
    logic [7:0] wr_bit_en8, rd_bit_oe8, rd_data_out8;

    sdram_lane_mask_ctrl #(.DATA_W(8)) u1 (
        .clk(clk), .rst_n(rst_n), .wr_beat(wr_beat8), .rd_beat(rd_beat8),
        .dqm(dqm8), .rd_data_in(rd_data_in8), .wr_lane_en(wr_lane_en8),
        .wr_bit_en(wr_bit_en8), .rd_lane_oe(rd_lane_oe8), .rd_bit_oe(rd_bit_oe8),
        .rd_data_out(rd_data_out8)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    // Row: {wr, rd, dqm[1:0], exp_wr_lane[1:0], exp_oe_now[1:0]}.
    // exp_oe_now is set by the row two steps earlier (R3).
    localparam int NROW = 14;
    localparam logic [7:0] VEC [NROW] = '{
        8'b1_0_00_11_00,  // R2 both lanes written
        8'b1_0_01_10_00,  // R5 low lane masked
        8'b1_0_10_01_00,  // R5 high lane masked
        8'b1_0_11_00_00,  // R4 fully masked beat in burst
        8'b0_1_00_00_00,
        8'b0_1_01_00_00,
        8'b0_1_10_00_11,  // R3 row 4 shows up
        8'b0_1_11_00_10,  // R3 row 5: low lane off
        8'b0_0_00_00_01,  // R3 row 6: high lane off
        8'b0_1_00_00_00,  // R4 row 7 fully masked
        8'b0_0_11_00_00,  // R8 mask without beat
        8'b1_0_00_11_11,  // R4 row 9 unaffected by neighbour
        8'b0_0_00_00_00,  // R8 row 10 gave no enable
        8'b0_0_11_00_00
    };

    localparam logic [15:0] RD_PAT = 16'hA5C3;

    initial begin : watchdog
        #200000;
        bad++; total++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin : main
        wr_beat = 0; rd_beat = 0; dqm = 2'b11; rd_data_in = RD_PAT;
        wr_beat8 = 0; rd_beat8 = 0; dqm8 = 1'b1; rd_data_in8 = 8'h5A;
        rst_n = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset state
        check("R1 oe after reset", {30'd0, rd_lane_oe}, 32'd0);
        check("R1 data after reset", {16'd0, rd_data_out}, 32'd0);
        rst_n = 1;

        // Vector table walk on the 16-bit instance
        for (int i = 0; i < NROW; i++) begin
            logic [1:0] ew, eo;
            @(negedge clk);
            {wr_beat, rd_beat, dqm} = VEC[i][7:4];
            ew = VEC[i][3:2];
            eo = VEC[i][1:0];
            #1;
            check("R2/R5 wr_lane_en", {30'd0, wr_lane_en}, {30'd0, ew});
            check("R7 wr_bit_en", {16'd0, wr_bit_en}, {16'd0, {8{ew[1]}}, {8{ew[0]}}});
            check("R3/R4 rd_lane_oe", {30'd0, rd_lane_oe}, {30'd0, eo});
            check("R7 rd_data_out", {16'd0, rd_data_out},
                  {16'd0, RD_PAT & {{8{eo[1]}}, {8{eo[0]}}}});
            check("R7 rd_bit_oe", {16'd0, rd_bit_oe}, {16'd0, {8{eo[1]}}, {8{eo[0]}}});
        end

        // R1: reset while a read is in flight cancels it
        @(negedge clk);
        wr_beat = 0; rd_beat = 1; dqm = 2'b00;
        @(negedge clk);
        rd_beat = 0; rst_n = 0;
        @(negedge clk);
        #1;
        check("R1 in-flight read cleared", {30'd0, rd_lane_oe}, 32'd0);
        rst_n = 1;

        // R6: single mask bit covers the whole 8-bit bus
        @(negedge clk);
        wr_beat8 = 1; dqm8 = 1'b1;
        #1;
        check("R6 8-bit write masked", {24'd0, wr_bit_en8}, 32'd0);
        @(negedge clk);
        dqm8 = 1'b0;
        #1;
        check("R6 8-bit write open", {24'd0, wr_bit_en8}, 32'h0000_00FF);
        @(negedge clk);
        wr_beat8 = 0; rd_beat8 = 1; dqm8 = 1'b0;
        @(negedge clk);
        rd_beat8 = 1; dqm8 = 1'b1;
        @(negedge clk);
        rd_beat8 = 0; dqm8 = 1'b0;
        #1;
        check("R6 8-bit read enabled", {24'd0, rd_data_out8}, 32'h0000_005A);
        @(negedge clk);
        #1;
        check("R6 8-bit read disabled", {24'd0, rd_data_out8}, 32'd0);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule